// File: doc/BRIEF.md
# ISA Host Cycle Controller with Dynamic Width Sizing

This block is the host-side engine of a 16-bit AT-style expansion bus. A local requester hands it one access at a time: an address, write data, a direction, a memory or I/O space select and a width of one byte or one word. The controller runs the bus cycle. It pulses the address latch enable, drives the command strobe for the chosen space, drives the active-low high-byte enable, stretches the command while the slave pulls the channel-ready line low, and returns the read data with a one-cycle done pulse.

Transfer width is settled again on every word access. During the address phase the controller samples the 16-bit chip-select of the space in use. If the slave claims the access, the word moves in one 16-bit transfer. If it does not, the word is split into two byte transfers. The even byte goes first and the odd byte follows at the address plus one, and both bytes use data lines 0 to 7. A command that stays not-ready for longer than a programmable number of wait clocks is abandoned and reported as an error.

The request side uses a valid/ready handshake. `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where both `req_valid` and `req_ready` are high. While a cycle runs, `req_ready` stays low, so the requester keeps its request pending. There is no back-pressure on the response: `rsp_done` is a single-cycle pulse that must be taken when it occurs.

Top module: `isa_host_ctrl`

## Requirements
- R1: `req_ready` is high only in idle. An accepted request makes `bus_ale` high for exactly the next clock, with `bus_addr` already showing the access address (bit 0 cleared for word requests). `bus_addr` stays unchanged until the next address phase.
- R2: The address phase is followed by a command phase in which exactly one strobe is low for at least CMD_MIN clocks. With `bus_chrdy` high throughout, the phase lasts exactly CMD_MIN clocks. It is followed by one recovery clock with all strobes high.
- R3: Each clock in which `bus_chrdy` is low, once the minimum has elapsed, extends the command phase by one clock, up to `wait_limit` such clocks.
- R4: If `bus_chrdy` is still low after `wait_limit` wait clocks, the command ends after CMD_MIN+`wait_limit` clocks, any remaining byte transfer is skipped, and the done pulse carries `rsp_err`=1. Otherwise `rsp_err` is 0.
- R5: For a word request, the 16-bit chip-select of the request's own space (memory: `bus_mem_cs16_n`, I/O: `bus_io_cs16_n`, active low) is sampled in the address-phase clock. If it is low, one 16-bit transfer is made. The chip-select of the other space is ignored.
- R6: A word request that gets no 16-bit claim becomes two byte transfers: the even address first, then the address with bit 0 set. Each has its own address phase and command phase.
- R7: `bus_sbhe_n` is low during the address phase of the first transfer of a word request and during the command phase of a 16-bit transfer. It is high at all other times.
- R8: A memory read or write drives `bus_memr_n` or `bus_memw_n`. When address bits 23..20 are all zero, `bus_smemr_n` or `bus_smemw_n` is also driven low. An I/O access drives `bus_ior_n` or `bus_iow_n`.
- R9: `bus_doe` is high exactly during the command phase of a write. `bus_dout` carries the whole word on a 16-bit transfer. On a byte transfer it carries the byte on lines 7..0 (the low byte for the first or only byte, the high byte for the second) and zero on lines 15..8.
- R10: At the done pulse of a read, `rsp_rdata` holds the full bus word for a 16-bit transfer, or `{second lines 7..0, first lines 7..0}` for a split word, or `{8'h00, lines 7..0}` for a byte request.
- R11: `rsp_done` is high for exactly one clock, the clock after the last recovery clock, and `req_ready` rises in that same clock.
- R12: After reset the controller is idle with `req_ready`=1, `bus_ale`=0, `rsp_done`=0, and all strobes and `bus_sbhe_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| wait_limit | input | LIMIT_W | Number of wait clocks allowed before abort |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_err | output | 1 | Abort flag, valid with rsp_done |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| bus_addr | output | ADDR_W | Bus address |
| bus_ale | output | 1 | Address latch enable |
| bus_sbhe_n | output | 1 | High-byte enable, active low |
| bus_memr_n | output | 1 | Memory read strobe, full space |
| bus_memw_n | output | 1 | Memory write strobe, full space |
| bus_smemr_n | output | 1 | Memory read strobe, first megabyte only |
| bus_smemw_n | output | 1 | Memory write strobe, first megabyte only |
| bus_ior_n | output | 1 | I/O read strobe |
| bus_iow_n | output | 1 | I/O write strobe |
| bus_dout | output | DATA_W | Write data toward the bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the bus |
| bus_mem_cs16_n | input | 1 | Memory 16-bit claim, active low |
| bus_io_cs16_n | input | 1 | I/O 16-bit claim, active low |
| bus_chrdy | input | 1 | Channel ready, low inserts waits |

## Verification
The bench builds the controller with CMD_MIN=3 rather than the default of 2. This leaves two clocks before the wait window opens, so the bench can check that a low ready line before the minimum has elapsed is not counted. It drives `wait_limit` at 4 and then at 0. This covers waits exactly at the limit, waits one past it (abort), and an abort at the first wait clock. Together with 8-bit and 16-bit slave answers in both spaces, these values reach every sizing path: split, wide, wrong-space claim and abort in the middle of a split.

// File: rtl/isa_host_pkg.sv
package isa_host_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_CMD   = 2'd2,
    PH_RECOV = 2'd3
  } phase_e;
endpackage

// File: rtl/isa_cmd_timer.sv
// Counts command clocks up to the minimum, then counts wait clocks against the limit.
module isa_cmd_timer #(
  parameter int CMD_MIN = 2,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               chrdy,
  input  logic [LIMIT_W-1:0] limit,
  output logic               finish,
  output logic               abort
);
  localparam int CNT_W = (CMD_MIN < 2) ? 1 : $clog2(CMD_MIN);

  logic [CNT_W-1:0]   cnt;
  logic [LIMIT_W-1:0] wcnt;
  logic               min_ok;

  assign min_ok = (cnt >= CNT_W'(CMD_MIN - 1));
  assign finish = active && min_ok && chrdy;
  assign abort  = active && min_ok && !chrdy && (wcnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      wcnt <= '0;
    end else if (!active || finish || abort) begin
      cnt  <= '0;
      wcnt <= '0;
    end else if (!min_ok) begin
      cnt <= cnt + 1'b1;
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end
endmodule

// File: rtl/isa_strobe_dec.sv
// Picks the command strobe from space, direction and address range.
module isa_strobe_dec #(
  parameter int ADDR_W   = 24,
  parameter int LOW_MB_W = 20
) (
  input  logic              cmd_on,
  input  logic              is_io,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  output logic              memr_n,
  output logic              memw_n,
  output logic              smemr_n,
  output logic              smemw_n,
  output logic              ior_n,
  output logic              iow_n
);
  logic low_mb;

  generate
    if (ADDR_W > LOW_MB_W) begin : g_range
      assign low_mb = (addr[ADDR_W-1:LOW_MB_W] == '0);
    end else begin : g_all_low
      assign low_mb = 1'b1;
    end
  endgenerate

  always_comb begin
    memr_n  = !(cmd_on && !is_io && !is_write);
    memw_n  = !(cmd_on && !is_io &&  is_write);
    smemr_n = !(cmd_on && !is_io && !is_write && low_mb);
    smemw_n = !(cmd_on && !is_io &&  is_write && low_mb);
    ior_n   = !(cmd_on &&  is_io && !is_write);
    iow_n   = !(cmd_on &&  is_io &&  is_write);
  end
endmodule

// File: rtl/isa_lane_steer.sv
// Places write bytes on the lanes and collects read bytes into a word.
module isa_lane_steer #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              cap,
  input  logic              wide,
  input  logic              part,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANE_W = DATA_W / 2;

  always_comb begin
    if (wide) begin
      dout = wdata;
    end else begin
      dout = {{LANE_W{1'b0}}, (part ? wdata[DATA_W-1:LANE_W] : wdata[LANE_W-1:0])};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rdata <= '0;
    end else if (cap) begin
      if (wide) begin
        rdata <= din;
      end else if (part) begin
        rdata[DATA_W-1:LANE_W] <= din[LANE_W-1:0];
      end else begin
        rdata[LANE_W-1:0] <= din[LANE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/isa_host_ctrl.sv
module isa_host_ctrl
  import isa_host_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int CMD_MIN = 2,
  parameter int LIMIT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               req_write,
  input  logic               req_io,
  input  logic               req_word,
  input  logic [LIMIT_W-1:0] wait_limit,
  output logic               rsp_done,
  output logic               rsp_err,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic               bus_ale,
  output logic               bus_sbhe_n,
  output logic               bus_memr_n,
  output logic               bus_memw_n,
  output logic               bus_smemr_n,
  output logic               bus_smemw_n,
  output logic               bus_ior_n,
  output logic               bus_iow_n,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe,
  input  logic [DATA_W-1:0]  bus_din,
  input  logic               bus_mem_cs16_n,
  input  logic               bus_io_cs16_n,
  input  logic               bus_chrdy
);
  phase_e             phase;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               write_q, io_q, word_q, part_q, wide_q, abort_q;
  logic               done_q, err_q;
  logic               accept, cmd_on, cs16_hit, t_finish, t_abort, more;

  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign cmd_on    = (phase == PH_CMD);
  assign cs16_hit  = io_q ? !bus_io_cs16_n : !bus_mem_cs16_n;
  assign more      = word_q && !wide_q && !part_q && !abort_q;

  isa_cmd_timer #(.CMD_MIN(CMD_MIN), .LIMIT_W(LIMIT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .active(cmd_on), .chrdy(bus_chrdy),
    .limit(wait_limit), .finish(t_finish), .abort(t_abort)
  );

  isa_strobe_dec #(.ADDR_W(ADDR_W)) strobe_i (
    .cmd_on(cmd_on), .is_io(io_q), .is_write(write_q), .addr(addr_q),
    .memr_n(bus_memr_n), .memw_n(bus_memw_n), .smemr_n(bus_smemr_n),
    .smemw_n(bus_smemw_n), .ior_n(bus_ior_n), .iow_n(bus_iow_n)
  );

  isa_lane_steer #(.DATA_W(DATA_W)) lanes_i (
    .clk(clk), .rst_n(rst_n), .clear(accept), .cap(t_finish && !write_q),
    .wide(wide_q), .part(part_q), .wdata(wdata_q), .din(bus_din),
    .dout(bus_dout), .rdata(rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      io_q    <= 1'b0;
      word_q  <= 1'b0;
      part_q  <= 1'b0;
      wide_q  <= 1'b0;
      abort_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          done_q <= 1'b0;
          err_q  <= 1'b0;
          if (accept) begin
            addr_q  <= req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
            wdata_q <= req_wdata;
            write_q <= req_write;
            io_q    <= req_io;
            word_q  <= req_word;
            part_q  <= 1'b0;
            wide_q  <= 1'b0;
            abort_q <= 1'b0;
            phase   <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          wide_q <= word_q && !part_q && cs16_hit;
          phase  <= PH_CMD;
        end
        PH_CMD: begin
          if (t_abort) begin
            abort_q <= 1'b1;
            phase   <= PH_RECOV;
          end else if (t_finish) begin
            phase <= PH_RECOV;
          end
        end
        default: begin
          if (more) begin
            part_q    <= 1'b1;
            addr_q[0] <= 1'b1;
            phase     <= PH_ADDR;
          end else begin
            done_q <= 1'b1;
            err_q  <= abort_q;
            phase  <= PH_IDLE;
          end
        end
      endcase
    end
  end

  assign bus_addr   = addr_q;
  assign bus_ale    = (phase == PH_ADDR);
  assign bus_doe    = cmd_on && write_q;
  assign bus_sbhe_n = !(((phase == PH_ADDR) && word_q && !part_q) || (cmd_on && wide_q));
  assign rsp_done   = done_q;
  assign rsp_err    = err_q;
endmodule

// File: rtl/isa_host_ctrl_chk.sv
module isa_host_ctrl_chk #(
  parameter int ADDR_W  = 24,
  parameter int CMD_MIN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ale,
  input logic              bus_sbhe_n,
  input logic              bus_memr_n,
  input logic              bus_memw_n,
  input logic              bus_smemr_n,
  input logic              bus_smemw_n,
  input logic              bus_ior_n,
  input logic              bus_iow_n,
  input logic              bus_doe
);
  logic        cmd_act;
  int unsigned ccnt;

  assign cmd_act = !(bus_memr_n && bus_memw_n && bus_ior_n && bus_iow_n);

  always_ff @(posedge clk) begin
    if (!rst_n || !cmd_act) ccnt <= 0;
    else if (ccnt < CMD_MIN) ccnt <= ccnt + 1;
  end

  assert_ale_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_ale && !cmd_act));
  assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> $stable(bus_addr));
  assert_min_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_act && (ccnt < CMD_MIN - 1)) |=> cmd_act);
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!bus_memr_n, !bus_memw_n, !bus_ior_n, !bus_iow_n}) <= 1);
  assert_smem_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((!bus_smemr_n |-> !bus_memr_n) and (!bus_smemw_n |-> !bus_memw_n)));
  assert_sbhe_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sbhe_n |-> (bus_ale || cmd_act));
  assert_doe_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (!bus_memw_n || !bus_iow_n));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind isa_host_ctrl isa_host_ctrl_chk #(.ADDR_W(ADDR_W), .CMD_MIN(CMD_MIN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_sbhe_n(bus_sbhe_n),
  .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n), .bus_smemr_n(bus_smemr_n),
  .bus_smemw_n(bus_smemw_n), .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
  .bus_doe(bus_doe)
);

// File: tb/isa_host_ctrl_tb_top.sv
module isa_host_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CMD_MIN    = 3;
  localparam int MAX_CYC    = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_write = 1'b0, req_io = 1'b0, req_word = 1'b0;
  logic [7:0]  wait_limit = 8'd4;
  logic        rsp_done, rsp_err;
  logic [15:0] rsp_rdata;
  logic [23:0] bus_addr;
  logic        bus_ale, bus_sbhe_n, bus_memr_n, bus_memw_n, bus_smemr_n, bus_smemw_n;
  logic        bus_ior_n, bus_iow_n, bus_doe;
  logic [15:0] bus_dout, bus_din;
  logic        bus_mem_cs16_n = 1'b1, bus_io_cs16_n = 1'b1, bus_chrdy = 1'b1;

  logic        tb_wide = 1'b0;
  logic [15:0] tb_pat = '0;
  logic [23:0] last_addr = '0;
  int          n_run = 0, n_fail = 0, cyc = 0;
  bit          finished = 0;

  typedef struct packed {
    logic        ale, rdy, done, err, sbhe_n;
    logic [23:0] addr;
    logic [5:0]  strb;   // {memr, memw, smemr, smemw, ior, iow} active high
    logic        oe;
    logic [15:0] dout;
    logic        chrdy;
  } cyc_t;
  cyc_t q[$];

  // Slave model: 16-bit slave drives the word; 8-bit slave answers on lines 7..0 only.
  assign bus_din = tb_wide ? tb_pat : {8'hA5, (bus_addr[0] ? tb_pat[15:8] : tb_pat[7:0])};

  always #(CLK_PERIOD/2) clk = ~clk;

  isa_host_ctrl #(.CMD_MIN(CMD_MIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
    .req_io(req_io), .req_word(req_word), .wait_limit(wait_limit),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_sbhe_n(bus_sbhe_n),
    .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n), .bus_smemr_n(bus_smemr_n),
    .bus_smemw_n(bus_smemw_n), .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n),
    .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_mem_cs16_n(bus_mem_cs16_n), .bus_io_cs16_n(bus_io_cs16_n),
    .bus_chrdy(bus_chrdy)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [5:0] strb_now();
    return {!bus_memr_n, !bus_memw_n, !bus_smemr_n, !bus_smemw_n, !bus_ior_n, !bus_iow_n};
  endfunction

  task automatic cmp(input cyc_t e);
    chk(req_ready == e.rdy, "R1 req_ready", 32'(req_ready), 32'(e.rdy));
    chk(bus_ale == e.ale, "R1 ale", 32'(bus_ale), 32'(e.ale));
    chk(bus_addr == e.addr, "R1 R6 bus_addr", 32'(bus_addr), 32'(e.addr));
    chk(bus_sbhe_n == e.sbhe_n, "R7 sbhe_n", 32'(bus_sbhe_n), 32'(e.sbhe_n));
    chk(strb_now() == e.strb, "R2 R3 R8 strobes", 32'(strb_now()), 32'(e.strb));
    chk(bus_doe == e.oe, "R9 doe", 32'(bus_doe), 32'(e.oe));
    if (e.oe) chk(bus_dout == e.dout, "R9 dout", 32'(bus_dout), 32'(e.dout));
    chk(rsp_done == e.done, "R11 done", 32'(rsp_done), 32'(e.done));
    if (e.done) chk(rsp_err == e.err, "R4 err", 32'(rsp_err), 32'(e.err));
  endtask

  task automatic run_req(input logic wr, input logic io, input logic word,
                         input logic [23:0] a_in, input logic [15:0] wd,
                         input logic mcs, input logic iocs,
                         input int w0, input int w1, input logic [15:0] pat);
    cyc_t c;
    logic wide, ab;
    logic [23:0] a;
    logic [15:0] exp_rd;
    int parts, lim;
    lim   = int'(wait_limit);
    wide  = word && (io ? iocs : mcs);
    parts = (word && !wide) ? 2 : 1;
    ab    = 1'b0;
    a     = a_in;
    q.delete();
    c = '0; c.rdy = 1; c.sbhe_n = 1; c.addr = last_addr; c.chrdy = 1;
    q.push_back(c);
    for (int p = 0; p < parts && !ab; p++) begin
      int w, n;
      a = word ? {a_in[23:1], 1'b0} : a_in;
      if (p == 1) a[0] = 1'b1;
      c = '0; c.ale = 1; c.addr = a; c.sbhe_n = !(word && p == 0); c.chrdy = 1;
      q.push_back(c);
      w  = (p == 0) ? w0 : w1;
      ab = (w > lim);
      n  = ab ? CMD_MIN + lim : CMD_MIN + w;
      for (int k = 0; k < n; k++) begin
        c = '0; c.addr = a; c.sbhe_n = !wide; c.oe = wr;
        c.strb = {!io && !wr, !io && wr, !io && !wr && (a < 24'h100000),
                  !io && wr && (a < 24'h100000), io && !wr, io && wr};
        c.dout = {(wide ? wd[15:8] : 8'h00), ((p == 1) ? wd[15:8] : wd[7:0])};
        c.chrdy = !((k >= CMD_MIN - 1) && (k - (CMD_MIN - 1) < w));
        q.push_back(c);
      end
      c = '0; c.addr = a; c.sbhe_n = 1; c.chrdy = 1;
      q.push_back(c);
    end
    c = '0; c.rdy = 1; c.done = 1; c.err = ab; c.addr = a; c.sbhe_n = 1; c.chrdy = 1;
    q.push_back(c);
    last_addr = a;
    if (wide) exp_rd = pat;
    else if (word) exp_rd = pat;
    else exp_rd = {8'h00, (a_in[0] ? pat[15:8] : pat[7:0])};

    bus_mem_cs16_n = !mcs;
    bus_io_cs16_n  = !iocs;
    tb_wide = wide;
    tb_pat  = pat;
    foreach (q[i]) begin
      @(negedge clk);
      cmp(q[i]);
      bus_chrdy = q[i].chrdy;
      if (i == 0) begin
        req_valid = 1; req_addr = a_in; req_wdata = wd;
        req_write = wr; req_io = io; req_word = word;
      end else if (i == 1) begin
        req_valid = 0;
      end
      if (q[i].done && !wr && !ab)
        chk(rsp_rdata == exp_rd, "R10 rdata", 32'(rsp_rdata), 32'(exp_rd));
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > MAX_CYC && !finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, MAX_CYC);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12: idle state after reset
    chk(req_ready == 1 && bus_ale == 0 && rsp_done == 0, "R12 idle", {req_ready, bus_ale, rsp_done}, 32'b100);
    chk(strb_now() == 6'b0 && bus_sbhe_n == 1, "R12 strobes", {strb_now(), bus_sbhe_n}, 32'b1);

    // R5: memory word write, 16-bit claim, first megabyte
    run_req(1, 0, 1, 24'h001234, 16'hCAFE, 1, 0, 0, 0, 16'h0000);
    // R6: memory word read to 8-bit slave is split
    run_req(0, 0, 1, 24'h0C0010, 16'h0000, 0, 0, 0, 0, 16'hBEEF);
    // R3: 16-bit read above 1 MB with two wait clocks
    run_req(0, 0, 1, 24'h200100, 16'h0000, 1, 0, 2, 0, 16'h1234);
    // R5: I/O word write claimed by the I/O chip-select
    run_req(1, 1, 1, 24'h000300, 16'h5A3C, 0, 1, 0, 0, 16'h0000);
    // R5: I/O word read where only the memory chip-select answers, so it is split
    run_req(0, 1, 1, 24'h000310, 16'h0000, 1, 0, 0, 0, 16'h7788);
    // R10: byte read at odd memory address
    run_req(0, 0, 0, 24'h000071, 16'h0000, 1, 1, 0, 0, 16'hD2C1);
    // R9: byte write to odd I/O address goes on lines 7..0
    run_req(1, 1, 0, 24'h000301, 16'h0099, 0, 0, 0, 0, 16'h0000);
    // R1: word request at odd address is aligned down
    run_req(0, 0, 1, 24'h000457, 16'h0000, 1, 0, 0, 0, 16'h4321);
    // R3 R6: split read, second byte waits exactly the limit
    run_req(0, 0, 1, 24'h0D0000, 16'h0000, 0, 0, 1, 4, 16'h6655);
    // R4: split write aborted in first byte, second skipped
    run_req(1, 0, 1, 24'h000800, 16'hABCD, 0, 0, 10, 0, 16'h0000);
    // R11: normal access after abort
    run_req(0, 1, 1, 24'h000220, 16'h0000, 0, 1, 1, 0, 16'h0F0E);
    // R4: limit 0 aborts at the first wait clock
    wait_limit = 8'd0;
    run_req(0, 0, 1, 24'h300000, 16'h0000, 1, 0, 1, 0, 16'h1111);
    run_req(1, 0, 0, 24'h000010, 16'h00EE, 0, 0, 0, 0, 16'h0000);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule